// File: doc/BRIEF.md
# Transmit Byte Queue with Watermark Request

This block buffers outgoing frame bytes between a host and a serializer. The host pushes 16-bit words, low byte first. The serializer pulls single bytes. The block raises a request toward the host, or toward a DMA engine, whenever the free space can take the number of word writes that the active watermark selects.

The watermark field can be written at any time and reads back as written. The request logic ignores a newly written value until an update bit commits it. A commit empties the queue and loads the pending watermark. A retry-failure pulse from the transmit path does the same. A burst option keeps the request raised, once it is up, until only one word of space remains, or until two words remain while the host signals end of frame.

Top module: `tx_wm_fifo`

## Requirements
- R1: After the hardware reset, the queue is empty, `tx_overflow` is 0, `cfg_rdata` is 0 and `tx_req` is 1.
- R2: `cfg_rdata` returns the last written watermark code, burst bit and update bit exactly. A watermark written without the update bit does not change `tx_req`.
- R3: A config write with bit 2 set has the following effect at the next clock edge: the queue is emptied and the pending watermark becomes active. Bit 2 reads back as 1 for one cycle and is then cleared by hardware, unless a new write sets it again.
- R4: A `retry_fail` pulse empties the queue and makes the pending watermark active at the next edge. It also clears the update bit.
- R5: With burst off, `tx_req` equals (free bytes >= threshold). The threshold is 8 bytes for code 00 and 11, 16 bytes for code 01, and 24 bytes for code 10. Free bytes equal 32 minus the stored bytes.
- R6: With burst on (config bit 3), `tx_req` is 1 when free >= threshold. Once it was 1 in the previous cycle, it stays 1 while free > 2. It drops when free <= 2, or when free <= 4 while `host_eof` is 1.
- R7: An accepted host write stores bits [7:0] and then bits [15:8] as two bytes. A write with fewer than 2 free bytes, judged before any same-cycle read, is dropped and sets the sticky `tx_overflow`.
- R8: `ser_data` shows the oldest byte and `ser_rd` removes it. When the queue is empty, `ser_data` is 0, `ser_empty` is 1 and a read changes nothing.
- R9: `sw_rst` clears the queue, the overflow flag, every config field and the request hold, like the hardware reset.
- R10: Config layout: bits [1:0] hold the watermark code, bit 2 the update bit and bit 3 burst mode. Bits [7:4] are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| sw_rst | input | 1 | Synchronous software reset |
| retry_fail | input | 1 | Transmit-path reset pulse; commits the watermark and empties the queue |
| host_we | input | 1 | Host word write strobe |
| host_wdata | input | 16 | Host write word, low byte leaves first |
| host_eof | input | 1 | Host end-of-frame indication |
| ser_rd | input | 1 | Serializer byte read strobe |
| ser_data | output | 8 | Oldest stored byte, 0 when empty |
| ser_empty | output | 1 | Queue holds no bytes |
| cfg_we | input | 1 | Config register write strobe |
| cfg_wdata | input | 8 | Config write value |
| cfg_rdata | output | 8 | Config readback |
| tx_req | output | 1 | Data request toward the host |
| tx_overflow | output | 1 | Sticky dropped-write flag |

## Verification
The bench writes a watermark without committing it and checks that the request still follows the old threshold. A design that applied the value at once would drop the request too early. It drives burst mode down to exactly two and four free bytes, with and without end of frame. A wrong hysteresis would either release the host one word too late and overflow the queue, or cut a burst short. It writes into a queue with only one free byte and reads an empty queue. Off-by-one space arithmetic would show up there as corrupted byte order or a missing overflow flag. Random traffic with occasional commits, retries and software resets tracks every output against a cycle model.

// File: rtl/tfw_pkg.sv
package tfw_pkg;
  localparam int CFG_W = 8;

  typedef struct packed {
    logic       burst;
    logic       upd;
    logic [1:0] wm;
  } cfg_t;

  // threshold in bytes: (code+1) steps of word writes, code 3 aliases code 0
  function automatic int unsigned wm_bytes(logic [1:0] code, int unsigned step_writes);
    int unsigned c;
    c = (code == 2'b11) ? 0 : int'(code);
    return 2 * step_writes * (c + 1);
  endfunction

  function automatic int unsigned free_bytes(int unsigned depth, int unsigned used);
    return depth - used;
  endfunction
endpackage

// File: rtl/tfw_cfg.sv
module tfw_cfg
  import tfw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_rst,
  input  logic             retry_fail,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic [1:0]       wm_act,
  output logic             burst,
  output logic             commit
);
  cfg_t staged;
  cfg_t wr_fields;
  logic [1:0] wm_live;

  assign wr_fields = cfg_t'(cfg_wdata[3:0]);
  assign commit    = !sw_rst && (staged.upd || retry_fail);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged  <= '0;
      wm_live <= '0;
    end else if (sw_rst) begin
      staged  <= '0;
      wm_live <= '0;
    end else begin
      if (commit) wm_live <= staged.wm;
      if (cfg_we) staged <= wr_fields;
      else if (commit) staged.upd <= 1'b0;
    end
  end

  assign cfg_rdata = {{(CFG_W-4){1'b0}}, staged};
  assign wm_act    = wm_live;
  assign burst     = staged.burst;

  // R3: the update bit clears itself unless re-armed
  a_r3_upd_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
    (staged.upd && !cfg_we) |=> !staged.upd);
  // R2: the active watermark moves only on a commit
  a_r2_wm_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !sw_rst) |=> $stable(wm_live));
  // R4: a retry pulse loads the staged value
  a_r4_retry_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (retry_fail && !sw_rst) |=> (wm_live == $past(staged.wm)));
endmodule

// File: rtl/tfw_store.sv
module tfw_store #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [15:0]   wr_data,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          empty,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] space;
  logic          hold_off, wr_acc, wr_drop, rd_acc;
  logic [CW-1:0] count_nxt;

  assign space     = CW'(tfw_pkg::free_bytes(DEPTH, int'(count)));
  assign hold_off  = flush || sw_rst;
  assign wr_acc    = wr_en && !hold_off && (space >= CW'(2));
  assign wr_drop   = wr_en && !hold_off && (space < CW'(2));
  assign rd_acc    = rd_en && !hold_off && (count != '0);
  assign count_nxt = count + (wr_acc ? CW'(2) : CW'(0)) - (rd_acc ? CW'(1) : CW'(0));
  assign empty     = (count == '0);
  assign rd_data   = empty ? 8'h00 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_acc) begin
      mem[wr_ptr]          <= wr_data[7:0];
      mem[wr_ptr + AW'(1)] <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; overflow <= 1'b0;
    end else if (sw_rst) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0; overflow <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (wr_acc) wr_ptr <= wr_ptr + AW'(2);
      if (rd_acc) rd_ptr <= rd_ptr + AW'(1);
      count <= count_nxt;
      if (wr_drop) overflow <= 1'b1;
    end
  end

  // R7: occupancy never exceeds the depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R7: the overflow flag is sticky
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !sw_rst) |=> overflow);
  // R8: an empty read with no write leaves the queue empty
  a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && empty && !wr_en) |=> empty);
  // R3: a flush leaves nothing behind
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
endmodule

// File: rtl/tfw_req.sv
module tfw_req #(
  parameter int DEPTH      = 32,
  parameter int STEP_WRITES = 4,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_rst,
  input  logic [CW-1:0] count,
  input  logic [1:0]    wm_act,
  input  logic          burst,
  input  logic          eof,
  output logic          req
);
  logic [CW-1:0] space, thr;
  logic          reach, keep, req_hold;

  assign space = CW'(tfw_pkg::free_bytes(DEPTH, int'(count)));
  assign thr   = CW'(tfw_pkg::wm_bytes(wm_act, STEP_WRITES));
  assign reach = (space >= thr);
  assign keep  = req_hold && (space > CW'(2)) && !(eof && (space <= CW'(4)));
  assign req   = reach || (burst && keep);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      req_hold <= 1'b0;
    else if (sw_rst) req_hold <= 1'b0;
    else             req_hold <= req;
  end

  // R6: burst mode withdraws the request with one word of space left
  a_r6_burst_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && space <= CW'(2)) |-> !req);
  // R6: burst mode keeps a raised request while more than a word fits
  a_r6_burst_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (burst && !$past(sw_rst) && $past(req) && space > CW'(4)) |-> req);
  // R5: normal mode never requests below the threshold
  a_r5_normal_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!burst && space < thr) |-> !req);
endmodule

// File: rtl/tx_wm_fifo.sv
module tx_wm_fifo #(
  parameter int DEPTH       = 32,
  parameter int STEP_WRITES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sw_rst,
  input  logic        retry_fail,
  input  logic        host_we,
  input  logic [15:0] host_wdata,
  input  logic        host_eof,
  input  logic        ser_rd,
  output logic [7:0]  ser_data,
  output logic        ser_empty,
  input  logic        cfg_we,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  output logic        tx_req,
  output logic        tx_overflow
);
  localparam int CW = $clog2(DEPTH) + 1;

  logic [1:0]    wm_act;
  logic          burst, commit;
  logic [CW-1:0] count;

  tfw_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .retry_fail(retry_fail),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .wm_act(wm_act), .burst(burst), .commit(commit)
  );

  tfw_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .flush(commit),
    .wr_en(host_we), .wr_data(host_wdata), .rd_en(ser_rd),
    .rd_data(ser_data), .empty(ser_empty), .count(count), .overflow(tx_overflow)
  );

  tfw_req #(.DEPTH(DEPTH), .STEP_WRITES(STEP_WRITES)) u_req (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .count(count),
    .wm_act(wm_act), .burst(burst), .eof(host_eof), .req(tx_req)
  );

  // R3: a commit is followed by an empty queue
  a_r3_commit_empty: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ser_empty);
  // R9: software reset clears the flag and config
  a_r9_swrst_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_rst && !cfg_we) |=> (!tx_overflow && cfg_rdata == 8'h00));
endmodule

// File: tb/tb_tx_wm_fifo.sv
`timescale 1ns/1ps
module tb_tx_wm_fifo;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_rst = 0, retry_fail = 0, host_we = 0, host_eof = 0, ser_rd = 0, cfg_we = 0;
  logic [15:0] host_wdata = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  ser_data, cfg_rdata;
  logic        ser_empty, tx_req, tx_overflow;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tx_wm_fifo dut (
    .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .retry_fail(retry_fail),
    .host_we(host_we), .host_wdata(host_wdata), .host_eof(host_eof),
    .ser_rd(ser_rd), .ser_data(ser_data), .ser_empty(ser_empty),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tx_req(tx_req), .tx_overflow(tx_overflow)
  );

  // reference state
  logic [7:0] q[$];
  logic [1:0] m_wm_pend, m_wm_act;
  logic       m_upd, m_burst, m_ovf, m_hold;

  task automatic model_clear();
    q.delete();
    m_wm_pend = 0; m_wm_act = 0; m_upd = 0; m_burst = 0; m_ovf = 0; m_hold = 0;
  endtask

  function automatic int thr_of(logic [1:0] c);
    case (c)
      2'b01:   return 16;
      2'b10:   return 24;
      default: return 8;
    endcase
  endfunction

  function automatic logic exp_req(logic eof);
    int fr;
    fr = 32 - q.size();
    if (fr >= thr_of(m_wm_act)) return 1'b1;
    return m_burst && m_hold && fr > 2 && !(eof && fr <= 4);
  endfunction

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // compare outputs for the inputs already driven, then advance the model one edge
  task automatic step();
    logic er;
    int fr;
    logic fl;
    #1;
    er = exp_req(host_eof);
    chk(m_burst ? "R6" : "R5", "tx_req", 16'(tx_req), 16'(er));
    chk("R8", "ser_data", 16'(ser_data), 16'(q.size() > 0 ? q[0] : 8'h00));
    chk("R8", "ser_empty", 16'(ser_empty), 16'(q.size() == 0));
    chk("R2", "cfg_rdata", 16'(cfg_rdata), 16'({4'b0, m_burst, m_upd, m_wm_pend}));
    chk("R7", "tx_overflow", 16'(tx_overflow), 16'(m_ovf));
    if (sw_rst) model_clear();
    else begin
      fr = 32 - q.size();
      fl = m_upd || retry_fail;
      if (fl) begin
        q.delete();
        m_wm_act = m_wm_pend;
      end else begin
        if (host_we && fr < 2) m_ovf = 1;
        if (ser_rd && q.size() > 0) void'(q.pop_front());
        if (host_we && fr >= 2) begin
          q.push_back(host_wdata[7:0]);
          q.push_back(host_wdata[15:8]);
        end
      end
      if (cfg_we) begin
        m_wm_pend = cfg_wdata[1:0]; m_upd = cfg_wdata[2]; m_burst = cfg_wdata[3];
      end else if (fl) m_upd = 0;
      m_hold = er;
    end
    @(negedge clk);
  endtask

  task automatic idle_in();
    sw_rst = 0; retry_fail = 0; host_we = 0; host_eof = 0; ser_rd = 0; cfg_we = 0;
    #1;
  endtask

  task automatic cyc(bit we, logic [15:0] d, bit eof, bit rd, bit cwe, logic [7:0] cd, bit rt, bit sw);
    host_we = we; host_wdata = d; host_eof = eof; ser_rd = rd;
    cfg_we = cwe; cfg_wdata = cd; retry_fail = rt; sw_rst = sw;
    step();
  endtask

  task automatic wr(logic [15:0] d);        cyc(1, d, 0, 0, 0, 0, 0, 0); endtask
  task automatic rd1();                     cyc(0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic cfg(logic [7:0] v);        cyc(0, 0, 0, 0, 1, v, 0, 0); endtask
  task automatic nop();                     cyc(0, 0, 0, 0, 0, 0, 0, 0); endtask

  initial begin : watchdog
    #(5ns * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5EED_1234));
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle_in();
    chk("R1", "tx_req after reset", 16'(tx_req), 16'h1);
    chk("R1", "cfg after reset", 16'(cfg_rdata), 16'h0);
    chk("R1", "overflow after reset", 16'(tx_overflow), 16'h0);
    chk("R1", "empty after reset", 16'(ser_empty), 16'h1);

    for (int i = 0; i < 16; i++) wr(16'hA000 + 16'(i * 257));
    idle_in();
    chk("R5", "req with full queue", 16'(tx_req), 16'h0);
    wr(16'hDEAD);
    idle_in();
    chk("R7", "overflow on full write", 16'(tx_overflow), 16'h1);
    for (int i = 0; i < 32; i++) rd1();
    rd1();
    idle_in();
    chk("R8", "empty read data", 16'(ser_data), 16'h0);
    chk("R8", "empty after drain", 16'(ser_empty), 16'h1);

    cfg(8'h02);
    idle_in();
    chk("R2", "staged readback", 16'(cfg_rdata), 16'h02);
    for (int i = 0; i < 5; i++) wr(16'h1100 + 16'(i));
    idle_in();
    chk("R2", "old threshold still used", 16'(tx_req), 16'h1);

    cfg(8'h06);
    idle_in();
    chk("R3", "update bit visible", 16'(cfg_rdata), 16'h06);
    nop();
    idle_in();
    chk("R3", "update bit cleared", 16'(cfg_rdata), 16'h02);
    chk("R3", "queue flushed", 16'(ser_empty), 16'h1);
    for (int i = 0; i < 5; i++) wr(16'h2200 + 16'(i));
    idle_in();
    chk("R3", "new threshold in force", 16'(tx_req), 16'h0);

    cfg(8'h0D);
    nop();
    for (int i = 0; i < 15; i++) wr(16'h3300 + 16'(i));
    idle_in();
    chk("R6", "burst drop at two free", 16'(tx_req), 16'h0);
    for (int i = 0; i < 14; i++) rd1();
    idle_in();
    chk("R6", "burst rearm at threshold", 16'(tx_req), 16'h1);
    for (int i = 0; i < 6; i++) wr(16'h4400 + 16'(i));
    idle_in();
    chk("R6", "burst held at four free", 16'(tx_req), 16'h1);
    cyc(0, 0, 1, 0, 0, 0, 0, 0);
    idle_in();
    chk("R6", "eof drop at four free", 16'(tx_req), 16'h0);

    cfg(8'h02);
    cyc(0, 0, 0, 0, 0, 0, 1, 0);
    idle_in();
    chk("R4", "retry flushes", 16'(ser_empty), 16'h1);
    for (int i = 0; i < 5; i++) wr(16'h5500 + 16'(i));
    idle_in();
    chk("R4", "retry committed threshold", 16'(tx_req), 16'h0);

    for (int i = 0; i < 16; i++) wr(16'h6600);
    cfg(8'h0B);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    idle_in();
    chk("R9", "swrst overflow", 16'(tx_overflow), 16'h0);
    chk("R9", "swrst cfg", 16'(cfg_rdata), 16'h0);
    chk("R9", "swrst empty", 16'(ser_empty), 16'h1);
    chk("R9", "swrst req", 16'(tx_req), 16'h1);

    cfg(8'hF1);
    idle_in();
    chk("R10", "upper bits ignored", 16'(cfg_rdata), 16'h01);

    for (int i = 0; i < 6000; i++) begin
      bit fillp;
      logic [7:0] cd;
      fillp = ((i / 250) % 2) == 0;
      cd = 8'($urandom);
      if ($urandom % 3 != 0) cd[2] = 1'b0;
      cyc(($urandom % 100) < (fillp ? 70 : 25), 16'($urandom), ($urandom % 4) == 0,
          ($urandom % 100) < (fillp ? 25 : 70), ($urandom % 40) == 0, cd,
          ($urandom % 300) == 0, ($urandom % 900) == 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule